// File: doc/BRIEF.md
# Two-Way Set-Associative Translation Buffer

This block keeps the most recently used virtual-to-physical page translations for 4 KB pages, so an address can be translated without going back to the page table. The default build holds 64 entries: two ways of 32 sets. A lookup presents a 52-bit virtual address. One cycle later the block reports one of two results. On a hit it returns the 32-bit physical address, the protection bits and the referenced/changed status of the page. On a miss it raises a miss flag. The page offset (address bits 11:0) passes through untranslated.

After a miss, the table search runs outside this block. Its result comes back through the refill port, which writes one entry. Two invalidate paths exist. A selective invalidate clears both ways of one set. A global flush clears all entries, one set per cycle. Instruction and data translations use two separate instances of this block.

A small controller has two named states. In ST_IDLE it accepts one request per cycle in this priority order: global flush, selective invalidate, refill, lookup. The transition IDLE→FLUSH happens when a global flush is accepted; that same cycle clears set 0. In ST_FLUSH the controller clears one set per cycle. The transition FLUSH→IDLE happens after the cycle that clears the last set.

Top module: `tlb2w`

## Requirements
- R1: After reset every entry is invalid, `busy` is low and all lookup outputs are zero; any lookup then misses.
- R2: A lookup accepted at a clock edge has its result on the outputs after that edge (`lk_done` high for one cycle). On a hit, `lk_paddr` is {stored page number, `lk_vaddr[11:0]`} and `lk_prot` is the stored protection value.
- R3: The set index is `vaddr[16:12]` and the tag is `vaddr[51:17]`. A hit needs a valid entry in that set whose tag equals all 35 tag bits. A missing lookup changes no entry and no replacement state.
- R4: A refill (`rf_vpn` = vaddr[51:12]) chooses its way in this order: the way already holding that tag, then an invalid way 0, then an invalid way 1, otherwise the least-recently-used way. The written entry has referenced and changed cleared.
- R5: Each set has one replacement bit. A lookup hit or a refill into way w makes the other way the next victim.
- R6: A load hit sets the entry's referenced bit. A store hit (`lk_store`=1) sets both referenced and changed. `lk_ref`/`lk_chg` report the values after this update.
- R7: A selective invalidate clears both ways of set `inv_vaddr[16:12]` and leaves every other set intact.
- R8: A global flush clears all entries. `busy` is high for 31 cycles after the accept cycle. Lookup, refill and invalidate requests made while busy are dropped, and a dropped lookup gives no `lk_done`.
- R9: In idle, only the highest-priority request of one cycle is performed (flush > selective invalidate > refill > lookup). The others are dropped, and a dropped lookup gives no `lk_done`.
- R10: On a miss, `lk_miss` is high and `lk_hit`, `lk_paddr`, `lk_prot`, `lk_ref`, `lk_chg` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 52 | Virtual address to translate |
| lk_store | input | 1 | Lookup is a store (1) or load (0) |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Translation not found |
| lk_paddr | output | 32 | Physical address on a hit |
| lk_prot | output | 2 | Protection bits on a hit |
| lk_ref | output | 1 | Referenced status after update |
| lk_chg | output | 1 | Changed status after update |
| rf_valid | input | 1 | Refill request |
| rf_vpn | input | 40 | Virtual page number to install |
| rf_ppn | input | 20 | Physical page number to install |
| rf_prot | input | 2 | Protection bits to install |
| inv_valid | input | 1 | Selective set invalidate request |
| inv_vaddr | input | 52 | Address that selects the set to invalidate |
| inv_all | input | 1 | Global flush request |
| busy | output | 1 | Global flush in progress |

## Verification
The embedded assertions check, on every cycle, several properties. Hit and miss are never reported together. At most one way matches a lookup. A result appears exactly one cycle after an accepted lookup. A changed page is also shown as referenced. No way is written and cleared in the same cycle. The flush counter advances one set per cycle from entry to exit. Only the bench scenarios show the rest: the refill victim choice, the replacement order over a run of accesses, the per-set reach of an invalidate, and the outcome of colliding requests. The bench shows these by comparing every lookup across all 64 entries with an arithmetic model of the requirements.

// File: rtl/tlb2w_pkg.sv
package tlb2w_pkg;

    localparam int unsigned DEF_VA_W   = 52;
    localparam int unsigned DEF_PA_W   = 32;
    localparam int unsigned DEF_OFF_W  = 12;
    localparam int unsigned DEF_SET_W  = 5;
    localparam int unsigned DEF_PROT_W = 2;
    localparam int unsigned NUM_WAYS   = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FLUSH = 2'd1
    } ctl_state_e;

    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_LOOKUP    = 3'd1,
        OP_REFILL    = 3'd2,
        OP_INV_SET   = 3'd3,
        OP_FLUSH_SET = 3'd4
    } tlb_op_e;

endpackage

// File: rtl/tlb2w_ctrl.sv
module tlb2w_ctrl
    import tlb2w_pkg::*;
#(
    parameter int unsigned SET_W = DEF_SET_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic             rf_valid,
    input  logic             inv_valid,
    input  logic             inv_all,
    output tlb_op_e          op,
    output logic [SET_W-1:0] flush_idx,
    output logic             busy
);

    localparam int unsigned SETS = 1 << SET_W;
    localparam logic [SET_W-1:0] LAST_SET = SET_W'(SETS - 1);

    ctl_state_e       state, state_nx;
    logic [SET_W-1:0] cnt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && inv_all)
                cnt <= SET_W'(1);
            else if (state == ST_FLUSH)
                cnt <= cnt + SET_W'(1);
        end
    end

    // next state and per-cycle operation
    always_comb begin
        state_nx  = state;
        op        = OP_NONE;
        flush_idx = '0;
        unique case (state)
            ST_IDLE: begin
                if (inv_all) begin
                    op       = OP_FLUSH_SET;
                    state_nx = ST_FLUSH;
                end else if (inv_valid) begin
                    op = OP_INV_SET;
                end else if (rf_valid) begin
                    op = OP_REFILL;
                end else if (lk_valid) begin
                    op = OP_LOOKUP;
                end
            end
            ST_FLUSH: begin
                op        = OP_FLUSH_SET;
                flush_idx = cnt;
                if (cnt == LAST_SET)
                    state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign busy = (state == ST_FLUSH);

    p_flush_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FLUSH |=> (state == ST_IDLE && $past(cnt) == LAST_SET)
                              || (cnt == $past(cnt) + SET_W'(1)));

    p_flush_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && inv_all) |=> (busy && cnt == SET_W'(1)));

    p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> op == OP_FLUSH_SET);

endmodule

// File: rtl/tlb2w_way.sv
module tlb2w_way #(
    parameter int unsigned ENT_W = 60,
    parameter int unsigned SET_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] idx,
    output logic [ENT_W-1:0] rd_data,
    input  logic             wr_en,
    input  logic [ENT_W-1:0] wr_data,
    input  logic             clr_en
);

    localparam int unsigned SETS = 1 << SET_W;

    logic [ENT_W-1:0] mem [SETS];

    assign rd_data = mem[idx];

    // valid flag is the top bit of an entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++)
                mem[i] <= '0;
        end else if (clr_en) begin
            mem[idx][ENT_W-1] <= 1'b0;
        end else if (wr_en) begin
            mem[idx] <= wr_data;
        end
    end

    p_wr_clr_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && clr_en));

endmodule

// File: rtl/tlb2w.sv
module tlb2w
    import tlb2w_pkg::*;
#(
    parameter int unsigned VA_W   = DEF_VA_W,
    parameter int unsigned PA_W   = DEF_PA_W,
    parameter int unsigned OFF_W  = DEF_OFF_W,
    parameter int unsigned SET_W  = DEF_SET_W,
    parameter int unsigned PROT_W = DEF_PROT_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lk_valid,
    input  logic [VA_W-1:0]        lk_vaddr,
    input  logic                   lk_store,
    output logic                   lk_done,
    output logic                   lk_hit,
    output logic                   lk_miss,
    output logic [PA_W-1:0]        lk_paddr,
    output logic [PROT_W-1:0]      lk_prot,
    output logic                   lk_ref,
    output logic                   lk_chg,
    input  logic                   rf_valid,
    input  logic [VA_W-OFF_W-1:0]  rf_vpn,
    input  logic [PA_W-OFF_W-1:0]  rf_ppn,
    input  logic [PROT_W-1:0]      rf_prot,
    input  logic                   inv_valid,
    input  logic [VA_W-1:0]        inv_vaddr,
    input  logic                   inv_all,
    output logic                   busy
);

    localparam int unsigned VPN_W = VA_W - OFF_W;
    localparam int unsigned TAG_W = VPN_W - SET_W;
    localparam int unsigned PPN_W = PA_W - OFF_W;
    localparam int unsigned SETS  = 1 << SET_W;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [PPN_W-1:0]  ppn;
        logic [PROT_W-1:0] prot;
        logic              refd;
        logic              chgd;
    } ent_t;

    localparam int unsigned ENT_W = $bits(ent_t);

    tlb_op_e          op;
    logic [SET_W-1:0] flush_idx;
    logic [SET_W-1:0] idx;
    logic [TAG_W-1:0] cmp_tag;
    ent_t             rd_ent [NUM_WAYS];
    ent_t             wr_ent [NUM_WAYS];
    logic [NUM_WAYS-1:0] hit_w, wr_en, clr_en;
    logic [SETS-1:0]  lru;
    logic             victim;
    logic             any_hit;
    logic             hit_way;
    logic             sig_unused;

    assign sig_unused = ^{inv_vaddr[VA_W-1:OFF_W+SET_W], inv_vaddr[OFF_W-1:0]};

    tlb2w_ctrl #(.SET_W(SET_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_valid  (lk_valid),
        .rf_valid  (rf_valid),
        .inv_valid (inv_valid),
        .inv_all   (inv_all),
        .op        (op),
        .flush_idx (flush_idx),
        .busy      (busy)
    );

    // set and tag selection per operation
    always_comb begin
        idx     = lk_vaddr[OFF_W +: SET_W];
        cmp_tag = lk_vaddr[VA_W-1 -: TAG_W];
        unique case (op)
            OP_REFILL: begin
                idx     = rf_vpn[SET_W-1:0];
                cmp_tag = rf_vpn[VPN_W-1 -: TAG_W];
            end
            OP_INV_SET:   idx = inv_vaddr[OFF_W +: SET_W];
            OP_FLUSH_SET: idx = flush_idx;
            default: ;
        endcase
    end

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        tlb2w_way #(.ENT_W(ENT_W), .SET_W(SET_W)) u_way (
            .clk     (clk),
            .rst_n   (rst_n),
            .idx     (idx),
            .rd_data (rd_ent[w]),
            .wr_en   (wr_en[w]),
            .wr_data (wr_ent[w]),
            .clr_en  (clr_en[w])
        );

        assign hit_w[w]  = rd_ent[w].valid && (rd_ent[w].tag == cmp_tag);
        assign clr_en[w] = (op == OP_INV_SET) || (op == OP_FLUSH_SET);
        assign wr_en[w]  = ((op == OP_LOOKUP) && hit_w[w])
                        || ((op == OP_REFILL) && (victim == 1'(w)));

        always_comb begin
            wr_ent[w] = rd_ent[w];
            if (op == OP_REFILL) begin
                wr_ent[w].valid = 1'b1;
                wr_ent[w].tag   = cmp_tag;
                wr_ent[w].ppn   = rf_ppn;
                wr_ent[w].prot  = rf_prot;
                wr_ent[w].refd  = 1'b0;
                wr_ent[w].chgd  = 1'b0;
            end else begin
                wr_ent[w].refd = 1'b1;
                wr_ent[w].chgd = rd_ent[w].chgd | lk_store;
            end
        end
    end

    assign any_hit = |hit_w;
    assign hit_way = hit_w[1];

    // victim: matching way, then invalid way 0, invalid way 1, else LRU
    always_comb begin
        if (any_hit)
            victim = hit_way;
        else if (!rd_ent[0].valid)
            victim = 1'b0;
        else if (!rd_ent[1].valid)
            victim = 1'b1;
        else
            victim = lru[idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lru <= '0;
        end else if (op == OP_LOOKUP && any_hit) begin
            lru[idx] <= ~hit_way;
        end else if (op == OP_REFILL) begin
            lru[idx] <= ~victim;
        end
    end

    // registered lookup response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_done  <= 1'b0;
            lk_hit   <= 1'b0;
            lk_miss  <= 1'b0;
            lk_paddr <= '0;
            lk_prot  <= '0;
            lk_ref   <= 1'b0;
            lk_chg   <= 1'b0;
        end else begin
            lk_done  <= (op == OP_LOOKUP);
            lk_hit   <= (op == OP_LOOKUP) && any_hit;
            lk_miss  <= (op == OP_LOOKUP) && !any_hit;
            lk_paddr <= '0;
            lk_prot  <= '0;
            lk_ref   <= 1'b0;
            lk_chg   <= 1'b0;
            if (op == OP_LOOKUP && any_hit) begin
                lk_paddr <= {rd_ent[hit_way].ppn, lk_vaddr[OFF_W-1:0]};
                lk_prot  <= rd_ent[hit_way].prot;
                lk_ref   <= 1'b1;
                lk_chg   <= rd_ent[hit_way].chgd | lk_store;
            end
        end
    end

    p_hit_miss_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_miss));

    p_single_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_LOOKUP |-> $countones(hit_w) <= 1);

    p_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_LOOKUP |=> lk_done && (lk_hit || lk_miss));

    p_done_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_done |-> $past(lk_valid) && !$past(busy));

    p_chg_has_ref_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lk_chg |-> lk_ref && lk_hit);

    p_miss_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> (lk_paddr == '0) && !lk_ref);

endmodule

// File: tb/tlb2w_tb.sv
module tlb2w_tb;

    localparam int NSETS = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [51:0] lk_vaddr = '0;
    logic        lk_store = 1'b0;
    logic        lk_done, lk_hit, lk_miss, lk_ref, lk_chg;
    logic [31:0] lk_paddr;
    logic [1:0]  lk_prot;
    logic        rf_valid = 1'b0;
    logic [39:0] rf_vpn = '0;
    logic [19:0] rf_ppn = '0;
    logic [1:0]  rf_prot = '0;
    logic        inv_valid = 1'b0;
    logic [51:0] inv_vaddr = '0;
    logic        inv_all = 1'b0;
    logic        busy;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // model of the requirements
    bit          m_v   [NSETS][2];
    logic [34:0] m_tag [NSETS][2];
    logic [19:0] m_ppn [NSETS][2];
    logic [1:0]  m_prot[NSETS][2];
    bit          m_ref [NSETS][2];
    bit          m_chg [NSETS][2];
    bit          m_lru [NSETS];

    always #10 clk = ~clk;

    tlb2w u_dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_store(lk_store),
        .lk_done(lk_done), .lk_hit(lk_hit), .lk_miss(lk_miss),
        .lk_paddr(lk_paddr), .lk_prot(lk_prot), .lk_ref(lk_ref), .lk_chg(lk_chg),
        .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn), .rf_prot(rf_prot),
        .inv_valid(inv_valid), .inv_vaddr(inv_vaddr), .inv_all(inv_all),
        .busy(busy)
    );

    function automatic logic [51:0] mk_va(input logic [34:0] tag, input int s, input int off);
        return {tag, 5'(s), 12'(off)};
    endfunction

    function automatic logic [34:0] tag_of(input int k, input int s);
        return 35'(64'h5_1234_0000 + 64'(k) * 64'h3_0001_0007 + 64'(s) * 64'h101);
    endfunction

    function automatic logic [19:0] ppn_of(input int k, input int s);
        return 20'(k * 40503 + s * 977 + 17);
    endfunction

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic m_clear();
        for (int s = 0; s < NSETS; s++) begin
            m_v[s][0] = 0; m_v[s][1] = 0; m_lru[s] = 0;
        end
    endtask

    task automatic m_fill(input logic [39:0] vpn, input logic [19:0] ppn, input logic [1:0] pr);
        int s, w;
        logic [34:0] t;
        s = int'(vpn[4:0]);
        t = vpn[39:5];
        if (m_v[s][0] && m_tag[s][0] == t) w = 0;
        else if (m_v[s][1] && m_tag[s][1] == t) w = 1;
        else if (!m_v[s][0]) w = 0;
        else if (!m_v[s][1]) w = 1;
        else w = int'(m_lru[s]);
        m_v[s][w] = 1; m_tag[s][w] = t; m_ppn[s][w] = ppn; m_prot[s][w] = pr;
        m_ref[s][w] = 0; m_chg[s][w] = 0;
        m_lru[s] = (w == 0);
    endtask

    task automatic refill(input logic [51:0] va, input logic [19:0] ppn, input logic [1:0] pr);
        @(negedge clk);
        rf_valid = 1; rf_vpn = va[51:12]; rf_ppn = ppn; rf_prot = pr;
        @(negedge clk);
        rf_valid = 0;
        m_fill(va[51:12], ppn, pr);
    endtask

    task automatic look(input logic [51:0] va, input logic st, input string rq);
        int s, w;
        logic [34:0] t;
        bit eh;
        logic [31:0] ea;
        logic [1:0] ep;
        bit er, ec;
        s = int'(va[16:12]);
        t = va[51:17];
        w = -1;
        if (m_v[s][0] && m_tag[s][0] == t) w = 0;
        else if (m_v[s][1] && m_tag[s][1] == t) w = 1;
        eh = (w >= 0);
        ea = '0; ep = '0; er = 0; ec = 0;
        if (eh) begin
            m_ref[s][w] = 1;
            m_chg[s][w] = m_chg[s][w] | st;
            m_lru[s] = (w == 0);
            ea = {m_ppn[s][w], va[11:0]};
            ep = m_prot[s][w];
            er = 1; ec = m_chg[s][w];
        end
        @(negedge clk);
        lk_valid = 1; lk_vaddr = va; lk_store = st;
        @(negedge clk);
        lk_valid = 0; lk_store = 0;
        chk(rq, "done", 64'(lk_done), 64'(1));
        chk(rq, "hit", 64'({lk_hit, lk_miss}), 64'({eh, !eh}));
        chk(rq, "paddr", 64'(lk_paddr), 64'(ea));
        chk(rq, "prot/ref/chg", 64'({lk_prot, lk_ref, lk_chg}), 64'({ep, er, ec}));
    endtask

    task automatic look_all(input int kmax, input string rq);
        for (int s = 0; s < NSETS; s++)
            for (int k = 0; k < kmax; k++)
                look(mk_va(tag_of(k, s), s, s * 123 + k), 1'b0, rq);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int bcnt;
        m_clear();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1", "busy", 64'(busy), 64'(0));
        chk("R1", "outputs", 64'({lk_done, lk_hit, lk_miss, lk_paddr}), 64'(0));
        for (int s = 0; s < NSETS; s += 7)
            look(mk_va(tag_of(0, s), s, 0), 1'b0, "R1");

        // R4 invalid ways first, two tags per set
        for (int s = 0; s < NSETS; s++) begin
            refill(mk_va(tag_of(0, s), s, 0), ppn_of(0, s), 2'(s));
            refill(mk_va(tag_of(1, s), s, 0), ppn_of(1, s), 2'(s + 1));
        end
        // R2 R3 R6 load hits over all 64 entries
        look_all(2, "R2");
        // R6 store hits on one tag
        for (int s = 0; s < NSETS; s++)
            look(mk_va(tag_of(1, s), s, 5), 1'b1, "R6");
        // R10 R3 misses: unknown tag and a one-bit tag difference
        for (int s = 0; s < NSETS; s++) begin
            look(mk_va(tag_of(2, s), s, 9), 1'b0, "R10");
            look(mk_va(tag_of(0, s) ^ 35'(1 << (s % 35)), s, 9), 1'b0, "R3");
        end
        look_all(2, "R3");
        // R5 LRU: touch tag 0 last in even sets, tag 1 in odd sets, then refill a third tag
        for (int s = 0; s < NSETS; s++)
            look(mk_va(tag_of(s % 2, s), s, 1), 1'b0, "R5");
        for (int s = 0; s < NSETS; s++)
            refill(mk_va(tag_of(2, s), s, 0), ppn_of(2, s), 2'(3 - s));
        look_all(3, "R5");
        // R4 refill over a present tag keeps the way and clears status
        for (int s = 0; s < NSETS; s += 3) begin
            look(mk_va(tag_of(2, s), s, 2), 1'b1, "R4");
            refill(mk_va(tag_of(2, s), s, 0), ppn_of(4, s), 2'(1));
        end
        look_all(3, "R4");

        // R7 selective invalidate of every fourth set
        for (int s = 0; s < NSETS; s += 4) begin
            @(negedge clk);
            inv_valid = 1; inv_vaddr = mk_va(tag_of(7, s), s, 77);
            @(negedge clk);
            inv_valid = 0;
            m_v[s][0] = 0; m_v[s][1] = 0;
        end
        look_all(3, "R7");

        // R9 refill beats lookup in the same cycle
        @(negedge clk);
        rf_valid = 1; rf_vpn = mk_va(tag_of(5, 3), 3, 0) >> 12; rf_ppn = 20'hABCDE; rf_prot = 2'd2;
        lk_valid = 1; lk_vaddr = mk_va(tag_of(0, 3), 3, 0);
        @(negedge clk);
        rf_valid = 0; lk_valid = 0;
        chk("R9", "dropped lookup done", 64'(lk_done), 64'(0));
        m_fill(mk_va(tag_of(5, 3), 3, 0) >> 12, 20'hABCDE, 2'd2);
        look(mk_va(tag_of(5, 3), 3, 4), 1'b0, "R9");
        // R9 invalidate beats refill
        @(negedge clk);
        inv_valid = 1; inv_vaddr = mk_va(0, 6, 0);
        rf_valid = 1; rf_vpn = mk_va(tag_of(6, 6), 6, 0) >> 12; rf_ppn = 20'h12345; rf_prot = 2'd1;
        @(negedge clk);
        inv_valid = 0; rf_valid = 0;
        m_v[6][0] = 0; m_v[6][1] = 0;
        look(mk_va(tag_of(6, 6), 6, 0), 1'b0, "R9");
        look(mk_va(tag_of(1, 6), 6, 0), 1'b0, "R9");

        // R8 global flush, with a refill colliding and a lookup while busy
        @(negedge clk);
        inv_all = 1; rf_valid = 1; rf_vpn = mk_va(tag_of(8, 9), 9, 0) >> 12; rf_ppn = 20'h77777;
        @(negedge clk);
        inv_all = 0; rf_valid = 0;
        bcnt = 0;
        while (busy && bcnt < 100) begin
            bcnt++;
            if (bcnt == 4) begin
                lk_valid = 1; lk_vaddr = mk_va(tag_of(1, 1), 1, 0);
            end
            if (bcnt == 6) begin
                rf_valid = 1; rf_vpn = mk_va(tag_of(9, 31), 31, 0) >> 12;
            end
            @(negedge clk);
            lk_valid = 0; rf_valid = 0;
            if (bcnt == 4)
                chk("R8", "lookup while busy done", 64'(lk_done), 64'(0));
        end
        chk("R8", "busy cycles", 64'(bcnt), 64'(31));
        m_clear();
        look_all(3, "R8");
        look(mk_va(tag_of(8, 9), 9, 0), 1'b0, "R8");
        look(mk_va(tag_of(9, 31), 31, 0), 1'b0, "R8");
        // refill after flush works again
        refill(mk_va(tag_of(3, 12), 12, 0), ppn_of(3, 12), 2'd3);
        look(mk_va(tag_of(3, 12), 12, 12'hFFF), 1'b1, "R8");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule